// File: doc/BRIEF.md
# Thermal Trip Comparator with Fault Queue

This block watches two temperature streams, one from an on-die sensor and one from a remote sensor. Each stream arrives with its own sample-valid strobe. Every valid sample is compared against a trip limit for its channel. A per-channel fault queue raises that channel's trip only after a run of consecutive over-limit samples. The same queue releases the trip only after a run of consecutive samples that sit a hysteresis margin below the limit. The active-low alarm output is the OR of the two channel trips.

A mode input chooses where the limits come from. In firmware mode the block uses the software-programmed limits. In platform (ACPI) mode it uses fixed hardware trip limits, with two per channel. In platform mode the alarm also pushes the fan-control code to full scale while it is active. In firmware mode a latch option can make a trip sticky. Only a software clear strobe removes a sticky trip; the strobe is held for one cycle and then drops by itself. The ADC, the register bus and the analog stage lie outside the block.

Top module: `thermtrip_top`

## Requirements
- R1: A sample is over-limit when it is strictly greater than its channel's limit, with signed two's-complement comparison. Three consecutive valid over-limit samples on a channel trip that channel. `alarm_n` goes low in the cycle after the clock edge that takes the third sample. Cycles with the strobe low change nothing.
- R2: A valid sample that is not over-limit, arriving before the third over-limit sample, restarts the over-limit run from zero.
- R3: Outside the latched case, a tripped channel releases after three consecutive valid samples less than or equal to limit minus 5. That threshold saturates at -128.
- R4: A valid sample above the release threshold but not over the limit restarts both runs. An over-limit sample restarts the release run.
- R5: In platform mode (`acpi_mode`=1), each channel's limit is the signed minimum of its two hardware limits. Software limits have no effect.
- R6: In firmware mode (`acpi_mode`=0), each channel uses its software limit. Hardware limits have no effect.
- R7: `alarm_n` is low while either channel is tripped. It returns high only when both channels are released.
- R8: `fan_code_out` is 8'hFF when `acpi_mode`=1 and `alarm_n`=0. Otherwise it equals `fan_code_in`.
- R9: In firmware mode with `latch_mode`=1, a tripped channel never releases on its own. A one-cycle `clr_wr` pulse arms a clear bit at the next edge. At the edge after that, both trips and all runs are cleared and the bit drops.
- R10: A clear that acts while `acpi_mode`=1 has no effect.
- R11: After reset `alarm_n` is 1 and all runs are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| acpi_mode | input | 1 | 1 = hardware limits and fan override, 0 = software limits |
| latch_mode | input | 1 | Sticky trips in firmware mode |
| clr_wr | input | 1 | Software clear write strobe |
| int_vld | input | 1 | On-die sample valid |
| int_temp | input | 8 | On-die sample, signed degrees |
| ext_vld | input | 1 | Remote sample valid |
| ext_temp | input | 8 | Remote sample, signed degrees |
| sw_lim_int | input | 8 | Software limit, on-die |
| sw_lim_ext | input | 8 | Software limit, remote |
| hw_lim_int_a | input | 8 | Hardware limit A, on-die |
| hw_lim_int_b | input | 8 | Hardware limit B, on-die |
| hw_lim_ext_a | input | 8 | Hardware limit A, remote |
| hw_lim_ext_b | input | 8 | Hardware limit B, remote |
| fan_code_in | input | 8 | Programmed fan code |
| alarm_n | output | 1 | Thermal alarm, active low |
| fan_code_out | output | 8 | Fan code after override |

## Verification
The assertions assume three things about the inputs. Limits and mode inputs settle before the edge that samples them. `clr_wr` is a synchronous strobe. A sample is meaningful only in a cycle with its strobe high. The latch-hold and clear properties look one edge ahead. They take the mode seen at the triggering edge as the one that governs that update, so they stay valid even when the mode flips right after.

The stimulus keeps inputs stable across each edge by driving them only 1 ns after the rising edge. Random temperatures are drawn in a narrow window around the limits, so runs, breaks and release thresholds all occur often. Modes and clears change only occasionally, so runs can complete between those changes.

// File: rtl/thermtrip_pkg.sv
package thermtrip_pkg;
  localparam int TW = 8;
  localparam int NCH = 2;
  typedef logic signed [TW-1:0] temp_t;

  // limit minus margin, clamped at the most negative code
  function automatic temp_t hyst_thr(input temp_t lim, input int unsigned margin);
    logic signed [TW+1:0] wide;
    logic signed [TW+1:0] floor_v;
    wide    = (TW+2)'(lim) - (TW+2)'(margin);
    floor_v = -(TW+2)'(signed'(1 <<< (TW-1)));
    if (wide < floor_v) return temp_t'(floor_v);
    return temp_t'(wide);
  endfunction

  function automatic temp_t smin(input temp_t a, input temp_t b);
    return (a < b) ? a : b;
  endfunction
endpackage

// File: rtl/thermtrip_limsel.sv
module thermtrip_limsel
  import thermtrip_pkg::*;
(
  input  logic  acpi_mode,
  input  temp_t sw_lim,
  input  temp_t hw_lim_a,
  input  temp_t hw_lim_b,
  output temp_t lim
);
  temp_t hw_eff;
  always_comb begin
    hw_eff = smin(hw_lim_a, hw_lim_b);
    lim    = acpi_mode ? hw_eff : sw_lim;
  end
endmodule

// File: rtl/thermtrip_queue.sv
module thermtrip_queue
  import thermtrip_pkg::*;
#(
  parameter int QLEN = 3,
  parameter int HYST = 5,
  localparam int CW = $clog2(QLEN + 1)
)(
  input  logic          clk,
  input  logic          rst_n,
  input  logic          vld,
  input  temp_t         temp,
  input  temp_t         lim,
  input  logic          allow_rel,
  input  logic          clr,
  output logic          trip,
  output logic          is_over,
  output logic          is_below,
  output logic [CW-1:0] over_cnt,
  output logic [CW-1:0] rel_cnt
);
  localparam logic [CW-1:0] LAST = CW'(QLEN - 1);
  temp_t thr;

  always_comb begin
    thr      = hyst_thr(lim, HYST);
    is_over  = temp > lim;
    is_below = temp <= thr;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      trip     <= 1'b0;
      over_cnt <= '0;
      rel_cnt  <= '0;
    end else if (clr) begin
      trip     <= 1'b0;
      over_cnt <= '0;
      rel_cnt  <= '0;
    end else if (vld) begin
      if (is_over) begin
        rel_cnt <= '0;
        if (trip) begin
          over_cnt <= '0;
        end else if (over_cnt == LAST) begin
          trip     <= 1'b1;
          over_cnt <= '0;
        end else begin
          over_cnt <= over_cnt + 1'b1;
        end
      end else if (is_below) begin
        over_cnt <= '0;
        if (trip && allow_rel) begin
          if (rel_cnt == LAST) begin
            trip    <= 1'b0;
            rel_cnt <= '0;
          end else begin
            rel_cnt <= rel_cnt + 1'b1;
          end
        end else begin
          rel_cnt <= '0;
        end
      end else begin
        over_cnt <= '0;
        rel_cnt  <= '0;
      end
    end
  end
endmodule

// File: rtl/thermtrip_fanovr.sv
module thermtrip_fanovr #(
  parameter int FW = 8
)(
  input  logic          acpi_mode,
  input  logic          alarm_act,
  input  logic [FW-1:0] code_in,
  output logic [FW-1:0] code_out
);
  localparam logic [FW-1:0] FULL = '1;
  always_comb code_out = (acpi_mode && alarm_act) ? FULL : code_in;
endmodule

// File: rtl/thermtrip_top.sv
module thermtrip_top
  import thermtrip_pkg::*;
#(
  parameter int QLEN = 3,
  parameter int HYST = 5,
  localparam int CW = $clog2(QLEN + 1)
)(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        acpi_mode,
  input  logic        latch_mode,
  input  logic        clr_wr,
  input  logic        int_vld,
  input  logic [7:0]  int_temp,
  input  logic        ext_vld,
  input  logic [7:0]  ext_temp,
  input  logic [7:0]  sw_lim_int,
  input  logic [7:0]  sw_lim_ext,
  input  logic [7:0]  hw_lim_int_a,
  input  logic [7:0]  hw_lim_int_b,
  input  logic [7:0]  hw_lim_ext_a,
  input  logic [7:0]  hw_lim_ext_b,
  input  logic [7:0]  fan_code_in,
  output logic        alarm_n,
  output logic [7:0]  fan_code_out
);
  logic [NCH-1:0]  vld_v, trip_v, over_v, below_v;
  temp_t           temp_v [NCH];
  temp_t           sw_v [NCH];
  temp_t           hwa_v [NCH];
  temp_t           hwb_v [NCH];
  temp_t           lim_v [NCH];
  logic [CW-1:0]   ocnt_v [NCH];
  logic [CW-1:0]   rcnt_v [NCH];
  logic            clr_pend, clr_act, allow_rel, alarm_act;

  assign vld_v  = {ext_vld, int_vld};
  assign temp_v[0] = temp_t'(int_temp);
  assign temp_v[1] = temp_t'(ext_temp);
  assign sw_v[0]   = temp_t'(sw_lim_int);
  assign sw_v[1]   = temp_t'(sw_lim_ext);
  assign hwa_v[0]  = temp_t'(hw_lim_int_a);
  assign hwa_v[1]  = temp_t'(hw_lim_ext_a);
  assign hwb_v[0]  = temp_t'(hw_lim_int_b);
  assign hwb_v[1]  = temp_t'(hw_lim_ext_b);

  // clear bit: armed by the write, acts and drops one edge later
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) clr_pend <= 1'b0;
    else        clr_pend <= clr_wr;
  end

  assign clr_act   = clr_pend && !acpi_mode;
  assign allow_rel = acpi_mode || !latch_mode;

  for (genvar c = 0; c < NCH; c++) begin : g_ch
    thermtrip_limsel u_lim (
      .acpi_mode (acpi_mode),
      .sw_lim    (sw_v[c]),
      .hw_lim_a  (hwa_v[c]),
      .hw_lim_b  (hwb_v[c]),
      .lim       (lim_v[c])
    );
    thermtrip_queue #(.QLEN(QLEN), .HYST(HYST)) u_q (
      .clk       (clk),
      .rst_n     (rst_n),
      .vld       (vld_v[c]),
      .temp      (temp_v[c]),
      .lim       (lim_v[c]),
      .allow_rel (allow_rel),
      .clr       (clr_act),
      .trip      (trip_v[c]),
      .is_over   (over_v[c]),
      .is_below  (below_v[c]),
      .over_cnt  (ocnt_v[c]),
      .rel_cnt   (rcnt_v[c])
    );
  end

  assign alarm_act = |trip_v;
  assign alarm_n   = !alarm_act;

  thermtrip_fanovr #(.FW(8)) u_fan (
    .acpi_mode (acpi_mode),
    .alarm_act (alarm_act),
    .code_in   (fan_code_in),
    .code_out  (fan_code_out)
  );
endmodule

// File: rtl/thermtrip_chk.sv
module thermtrip_chk #(
  parameter int QLEN = 3,
  localparam int CW = $clog2(QLEN + 1)
)(
  input logic          clk,
  input logic          rst_n,
  input logic          acpi_mode,
  input logic          latch_mode,
  input logic          clr_pend,
  input logic          alarm_n,
  input logic [7:0]    fan_code_in,
  input logic [7:0]    fan_code_out,
  input logic [1:0]    vld_v,
  input logic [1:0]    over_v,
  input logic [1:0]    below_v,
  input logic [CW-1:0] ocnt0,
  input logic [CW-1:0] ocnt1,
  input logic [CW-1:0] rcnt0,
  input logic [CW-1:0] rcnt1
);
  p_alarm_needs_over_r1: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(alarm_n) |-> $past(|(vld_v & over_v)));

  p_runs_bounded_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (ocnt0 < CW'(QLEN)) && (ocnt1 < CW'(QLEN)) && (rcnt0 < CW'(QLEN)) && (rcnt1 < CW'(QLEN)));

  p_release_cause_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(alarm_n) |-> $past(clr_pend && !acpi_mode) || $past(|(vld_v & below_v)));

  p_fan_full_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (acpi_mode && !alarm_n) |-> (fan_code_out == 8'hFF));

  p_fan_pass_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (!acpi_mode || alarm_n) |-> (fan_code_out == fan_code_in));

  p_latch_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (!acpi_mode && latch_mode && !alarm_n && !clr_pend) |=> !alarm_n);

  p_clear_acts_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_pend && !acpi_mode) |=> alarm_n);

  p_clear_ignored_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_pend && acpi_mode && !alarm_n && !(|(vld_v & below_v))) |=> !alarm_n);
endmodule

bind thermtrip_top thermtrip_chk #(.QLEN(QLEN)) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .acpi_mode    (acpi_mode),
  .latch_mode   (latch_mode),
  .clr_pend     (clr_pend),
  .alarm_n      (alarm_n),
  .fan_code_in  (fan_code_in),
  .fan_code_out (fan_code_out),
  .vld_v        (vld_v),
  .over_v       (over_v),
  .below_v      (below_v),
  .ocnt0        (ocnt_v[0]),
  .ocnt1        (ocnt_v[1]),
  .rcnt0        (rcnt_v[0]),
  .rcnt1        (rcnt_v[1])
);

// File: tb/tb_thermtrip_top.sv
`timescale 1ns/1ps
module tb_thermtrip_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic acpi_mode = 0, latch_mode = 0, clr_wr = 0;
  logic int_vld = 0, ext_vld = 0;
  logic [7:0] int_temp = 0, ext_temp = 0;
  logic [7:0] sw_lim_int = 0, sw_lim_ext = 0;
  logic [7:0] hw_lim_int_a = 0, hw_lim_int_b = 0, hw_lim_ext_a = 0, hw_lim_ext_b = 0;
  logic [7:0] fan_code_in = 8'h40;
  logic alarm_n;
  logic [7:0] fan_code_out;

  int checks = 0, errors = 0;
  bit done = 0;

  // bench model state
  int m_oc[2], m_rc[2];
  bit m_tr[2];
  bit m_pend;

  always #2 clk = ~clk;

  thermtrip_top dut (.*);

  function automatic int sx(input logic [7:0] v);
    return (v >= 128) ? int'(v) - 256 : int'(v);
  endfunction

  function automatic int chan_limit(input int ch);
    int a, b;
    if (!acpi_mode) return sx(ch == 0 ? sw_lim_int : sw_lim_ext);
    a = sx(ch == 0 ? hw_lim_int_a : hw_lim_ext_a);
    b = sx(ch == 0 ? hw_lim_int_b : hw_lim_ext_b);
    return (b < a) ? b : a;
  endfunction

  function automatic int rel_level(input int lim);
    int t = lim - 5;
    return (t < -128) ? -128 : t;
  endfunction

  task automatic model_edge();
    bit clear_now = m_pend && !acpi_mode;
    bit can_rel = acpi_mode || !latch_mode;
    for (int ch = 0; ch < 2; ch++) begin
      int t, lim;
      bit v;
      v = (ch == 0) ? int_vld : ext_vld;
      t = sx(ch == 0 ? int_temp : ext_temp);
      lim = chan_limit(ch);
      if (clear_now) begin
        m_tr[ch] = 0; m_oc[ch] = 0; m_rc[ch] = 0;
      end else if (v) begin
        if (t > lim) begin
          m_rc[ch] = 0;
          if (m_tr[ch]) m_oc[ch] = 0;
          else begin
            m_oc[ch]++;
            if (m_oc[ch] == 3) begin m_tr[ch] = 1; m_oc[ch] = 0; end
          end
        end else if (t <= rel_level(lim)) begin
          m_oc[ch] = 0;
          if (m_tr[ch] && can_rel) begin
            m_rc[ch]++;
            if (m_rc[ch] == 3) begin m_tr[ch] = 0; m_rc[ch] = 0; end
          end else m_rc[ch] = 0;
        end else begin
          m_oc[ch] = 0; m_rc[ch] = 0;
        end
      end
    end
    m_pend = clr_wr;
  endtask

  task automatic compare(input string tag);
    logic exp_n;
    logic [7:0] exp_fan;
    exp_n = !(m_tr[0] || m_tr[1]);
    exp_fan = (acpi_mode && !exp_n) ? 8'hFF : fan_code_in;
    checks++;
    if (alarm_n !== exp_n) begin
      errors++;
      $display("FAIL %s alarm_n actual=%b expected=%b t=%0t", tag, alarm_n, exp_n, $time);
    end
    checks++;
    if (fan_code_out !== exp_fan) begin
      errors++;
      $display("FAIL %s fan_code_out actual=%h expected=%h t=%0t", tag, fan_code_out, exp_fan, $time);
    end
  endtask

  task automatic tick();
    model_edge();
    @(posedge clk); #1;
  endtask

  task automatic feed(input bit vi, input int ti, input bit ve, input int te, input string tag);
    int_vld = vi; int_temp = 8'(ti);
    ext_vld = ve; ext_temp = 8'(te);
    tick();
    int_vld = 0; ext_vld = 0;
    compare(tag);
  endtask

  task automatic clear_pulse(input string tag);
    clr_wr = 1; tick(); clr_wr = 0; compare(tag);
    tick(); compare(tag);
  endtask

  initial begin
    #(4 * 150000);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    for (int ch = 0; ch < 2; ch++) begin m_oc[ch] = 0; m_rc[ch] = 0; m_tr[ch] = 0; end
    m_pend = 0;
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    compare("R11 reset");

    // firmware mode, auto release
    sw_lim_int = 8'd50; sw_lim_ext = 8'd90;
    hw_lim_int_a = 8'd10; hw_lim_int_b = 8'd0;
    hw_lim_ext_a = 8'd10; hw_lim_ext_b = 8'd0;
    feed(1, 40, 0, 0, "R6 hw ignored"); feed(1, 40, 0, 0, "R6 hw ignored"); feed(1, 40, 0, 0, "R6 hw ignored");
    feed(1, 51, 0, 0, "R2"); feed(1, 51, 0, 0, "R2"); feed(1, 50, 0, 0, "R1 equal not over");
    feed(1, 51, 0, 0, "R2 restart"); feed(1, 51, 0, 0, "R2 restart");
    feed(0, 99, 0, 0, "R1 strobe low"); feed(1, 51, 0, 0, "R1 third over");
    feed(1, 46, 0, 0, "R4 neutral"); feed(1, 45, 0, 0, "R3"); feed(1, 45, 0, 0, "R3");
    feed(1, 60, 0, 0, "R4 over breaks release"); feed(1, 45, 0, 0, "R3"); feed(1, 45, 0, 0, "R3");
    feed(1, 46, 0, 0, "R4 neutral breaks release");
    feed(1, 45, 0, 0, "R3"); feed(1, 45, 0, 0, "R3"); feed(1, 45, 0, 0, "R3 released");

    // saturated release threshold
    sw_lim_int = 8'(-125);
    repeat (3) feed(1, -124, 0, 0, "R1 negative trip");
    feed(1, -127, 0, 0, "R3 sat neutral");
    repeat (3) feed(1, -128, 0, 0, "R3 saturated release");

    // platform mode
    acpi_mode = 1; fan_code_in = 8'h22;
    sw_lim_int = 8'd20; hw_lim_int_a = 8'd70; hw_lim_int_b = 8'd60;
    hw_lim_ext_a = 8'd55; hw_lim_ext_b = 8'd80;
    repeat (3) feed(1, 30, 0, 0, "R5 sw ignored");
    repeat (3) feed(1, 61, 0, 0, "R5 min limit trip R8");
    repeat (3) feed(0, 0, 1, 56, "R7 both tripped");
    clr_wr = 1; tick(); clr_wr = 0; compare("R10");
    tick(); compare("R10 clear ignored");
    repeat (3) feed(1, 55, 0, 0, "R7 one released");
    repeat (3) feed(0, 0, 1, 50, "R7 all released R8");

    // latched firmware mode
    acpi_mode = 0; latch_mode = 1; sw_lim_ext = 8'd30;
    repeat (3) feed(0, 0, 1, 31, "R9 trip");
    repeat (4) feed(0, 0, 1, 0, "R9 held");
    clear_pulse("R9 clear");
    latch_mode = 0;

    // random phase
    for (int i = 0; i < 4000; i++) begin
      int base;
      if ($urandom_range(0, 99) < 2) acpi_mode = $urandom_range(0, 1);
      if ($urandom_range(0, 99) < 2) latch_mode = $urandom_range(0, 1);
      if ($urandom_range(0, 199) < 2) begin
        sw_lim_int = 8'($urandom_range(0, 255)); sw_lim_ext = 8'($urandom_range(0, 255));
        hw_lim_int_a = 8'($urandom_range(0, 255)); hw_lim_int_b = 8'($urandom_range(0, 255));
        hw_lim_ext_a = 8'($urandom_range(0, 255)); hw_lim_ext_b = 8'($urandom_range(0, 255));
      end
      clr_wr = ($urandom_range(0, 99) < 3);
      fan_code_in = 8'($urandom_range(0, 255));
      base = chan_limit(0);
      int_temp = 8'(base + int'($urandom_range(0, 12)) - 8);
      base = chan_limit(1);
      ext_temp = 8'(base + int'($urandom_range(0, 12)) - 8);
      int_vld = $urandom_range(0, 3) != 0;
      ext_vld = $urandom_range(0, 3) != 0;
      tick();
      compare("R1/R3/R7 random");
    end
    clr_wr = 0; int_vld = 0; ext_vld = 0;
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    void'($urandom(32'h5eed));
  end
endmodule